// File: doc/BRIEF.md
# Host Parallel Bus Port for a Character Display Controller

This block joins a character display controller core to a host processor. The host uses a strobe bus with a register-select line, a read/write line, an enable strobe and eight data lines. The block brings the enable strobe into the core clock domain. It finds the falling edge of the strobe and assembles each completed write byte. It hands that byte to the core, tagged as either an instruction or a data byte. On reads it selects what to present on the bus: a status word made of the busy flag and the address counter, or RAM data supplied by the core. It also drives the output-enable for the external tri-state pads.

The port has two widths. In the full-width mode a byte moves in one strobe. In the narrow mode a byte moves in two strobes on data lines 7..4, upper nibble first. The host changes the width at run time with an instruction that arrives on this same bus, so the port watches its own instruction stream.

Top module: `hbus_port`

## Requirements
- R1: After reset the port is in full-width mode (`wide_mode_o` = 1), `bus_oe_o` is 0, no write is handed on, and the nibble pointer points at the upper nibble.
- R2: In full-width mode, a strobe with `rnw_i` = 0 hands on the byte on `bus_in_i` once, after the strobe falls. `wr_is_data_o` = 0 when `sel_i` = 0 (instruction) and 1 when `sel_i` = 1 (data).
- R3: `bus_oe_o` is 1 exactly while `rnw_i` = 1 and `strobe_i` = 1.
- R4: A full-width read with `sel_i` = 0 presents `{busy_i, addr_i[6:0]}` (busy in bit 7). It produces neither a write handoff nor a read acknowledge.
- R5: A full-width read with `sel_i` = 1 presents `rdata_i` and gives one single-cycle `rd_ack_o` pulse after the strobe falls.
- R6: An instruction byte whose bits 7..5 are 001 sets the width from bit 4 (1 = full, 0 = narrow). No other byte, and no data byte, changes the width.
- R7: In narrow mode a write takes two strobes. Lines 7..4 of the first strobe form bits 7..4 of the byte, and lines 7..4 of the second form bits 3..0. Lines 3..0 are ignored.
- R8: In narrow mode a status read takes two strobes. The first presents `{busy, addr[6:4]}` on lines 7..4 and the second presents `addr[3:0]`. Lines 3..0 read as 0.
- R9: In narrow mode a data read presents `rdata_i[7:4]` and then `rdata_i[3:0]` on lines 7..4. It acknowledges once, only after the second strobe.
- R10: After a width change the next strobe is treated as the upper nibble (in narrow mode) or as a whole byte (in full-width mode).
- R11: `wr_overrun_o` is 1 for a write handed on while `busy_i` is 1 at the strobe fall, and 0 otherwise.
- R12: The port hands on exactly one single-cycle `wr_valid_o` pulse per completed write byte, and none after the first nibble of a narrow write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rnw_i | input | 1 | 1 read, 0 write |
| strobe_i | input | 1 | Asynchronous enable strobe from host |
| bus_in_i | input | 8 | Data lines as seen from the pads |
| bus_out_o | output | 8 | Data to drive onto the pads |
| bus_oe_o | output | 1 | Pad output enable |
| busy_i | input | 1 | Core busy flag |
| addr_i | input | 7 | Core address counter |
| rdata_i | input | 8 | Core RAM read data |
| wr_valid_o | output | 1 | One-cycle pulse: write byte ready |
| wr_byte_o | output | 8 | Completed write byte (held) |
| wr_is_data_o | output | 1 | Tag: 1 data, 0 instruction |
| wr_overrun_o | output | 1 | Write arrived while core busy |
| rd_ack_o | output | 1 | One-cycle pulse: data read completed |
| wide_mode_o | output | 1 | 1 full-width, 0 narrow |

## Verification
Full-width writes of both tags, status reads with busy set and with busy clear, and data reads show that the two register-select targets are routed and tagged apart. Narrow transfers drive junk on lines 3..0 and use nibble values whose halves differ. A swapped, dropped or leaked nibble therefore yields a visibly different byte. Width changes are exercised both ways: one byte that only looks like a width change, and one real change, followed by a first-strobe read. Together they show the width decode and the pointer home position. A write taken while the core is busy is contrasted with one taken while it is idle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int AC_W   = BYTE_W - 1;
    localparam logic [2:0] WIDTH_OP_TAG = 3'b001;
    localparam int WIDTH_BIT = 4;

    typedef enum logic {
        KIND_INSTR = 1'b0,
        KIND_DATA  = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic              wide;
        logic              phase;
        logic [NIB_W-1:0]  hold;
        logic [BYTE_W-1:0] cap;
        logic              cap_sel;
        logic              cap_rnw;
        logic              wr_valid;
        logic [BYTE_W-1:0] wr_byte;
        xfer_kind_e        kind;
        logic              overrun;
        logic              rd_ack;
    } rx_state_t;
endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], strobe_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/hbus_rx.sv
module hbus_rx
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_i,
    input  logic              fall_i,
    input  logic              sel_i,
    input  logic              rnw_i,
    input  logic [BYTE_W-1:0] bus_in_i,
    input  logic              busy_i,
    output logic              wide_o,
    output logic              phase_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              wr_is_data_o,
    output logic              wr_overrun_o,
    output logic              rd_ack_o
);
    rx_state_t st_d, st_q;
    logic              done;
    logic [BYTE_W-1:0] byte_v;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        st_d.rd_ack   = 1'b0;
        done          = 1'b0;
        byte_v        = st_q.cap;

        if (level_i) begin
            st_d.cap     = bus_in_i;
            st_d.cap_sel = sel_i;
            st_d.cap_rnw = rnw_i;
        end

        if (fall_i) begin
            if (st_q.wide) begin
                done = 1'b1;
            end else if (!st_q.phase) begin
                st_d.hold  = st_q.cap[BYTE_W-1:NIB_W];
                st_d.phase = 1'b1;
            end else begin
                done       = 1'b1;
                byte_v     = {st_q.hold, st_q.cap[BYTE_W-1:NIB_W]};
                st_d.phase = 1'b0;
            end

            if (done) begin
                if (!st_q.cap_rnw) begin
                    st_d.wr_valid = 1'b1;
                    st_d.wr_byte  = byte_v;
                    st_d.kind     = xfer_kind_e'(st_q.cap_sel);
                    st_d.overrun  = busy_i;
                    if (!st_q.cap_sel &&
                        byte_v[BYTE_W-1:BYTE_W-3] == WIDTH_OP_TAG &&
                        byte_v[WIDTH_BIT] != st_q.wide) begin
                        st_d.wide  = byte_v[WIDTH_BIT];
                        st_d.phase = 1'b0;
                    end
                end else if (st_q.cap_sel) begin
                    st_d.rd_ack = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.wide <= 1'b1;
            st_q.kind <= KIND_INSTR;
        end else begin
            st_q <= st_d;
        end
    end

    assign wide_o       = st_q.wide;
    assign phase_o      = st_q.phase;
    assign wr_valid_o   = st_q.wr_valid;
    assign wr_byte_o    = st_q.wr_byte;
    assign wr_is_data_o = (st_q.kind == KIND_DATA);
    assign wr_overrun_o = st_q.overrun;
    assign rd_ack_o     = st_q.rd_ack;

    AST_HANDOFF_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_valid |-> $past(fall_i)); // R12
    AST_HANDOFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_valid |=> !st_q.wr_valid); // R12
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_ack |=> !st_q.rd_ack); // R5
    AST_WIDTH_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wide != $past(st_q.wide)) |-> (st_q.wr_valid && st_q.kind == KIND_INSTR)); // R6
    AST_POINTER_HOME_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wide != $past(st_q.wide)) |-> !st_q.phase); // R10
    AST_WIDE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wide |-> !st_q.phase); // R7
endmodule

// File: rtl/hbus_tx.sv
module hbus_tx
    import hbus_pkg::*;
(
    input  logic              wide_i,
    input  logic              phase_i,
    input  logic              sel_i,
    input  logic              rnw_i,
    input  logic              strobe_i,
    input  logic              busy_i,
    input  logic [AC_W-1:0]   addr_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [BYTE_W-1:0] bus_out_o,
    output logic              bus_oe_o
);
    logic [BYTE_W-1:0] word;
    logic [NIB_W-1:0]  nib;

    always_comb begin
        word = sel_i ? rdata_i : {busy_i, addr_i};
        nib  = phase_i ? word[NIB_W-1:0] : word[BYTE_W-1:NIB_W];
        if (wide_i) bus_out_o = word;
        else        bus_out_o = {nib, {NIB_W{1'b0}}};
        bus_oe_o = strobe_i & rnw_i;
    end
endmodule

// File: rtl/hbus_port.sv
module hbus_port
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rnw_i,
    input  logic              strobe_i,
    input  logic [BYTE_W-1:0] bus_in_i,
    output logic [BYTE_W-1:0] bus_out_o,
    output logic              bus_oe_o,
    input  logic              busy_i,
    input  logic [AC_W-1:0]   addr_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              wr_is_data_o,
    output logic              wr_overrun_o,
    output logic              rd_ack_o,
    output logic              wide_mode_o
);
    logic lvl, fall, wide, phase;

    hbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .level_o  (lvl),
        .fall_o   (fall)
    );

    hbus_rx u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_i      (lvl),
        .fall_i       (fall),
        .sel_i        (sel_i),
        .rnw_i        (rnw_i),
        .bus_in_i     (bus_in_i),
        .busy_i       (busy_i),
        .wide_o       (wide),
        .phase_o      (phase),
        .wr_valid_o   (wr_valid_o),
        .wr_byte_o    (wr_byte_o),
        .wr_is_data_o (wr_is_data_o),
        .wr_overrun_o (wr_overrun_o),
        .rd_ack_o     (rd_ack_o)
    );

    hbus_tx u_tx (
        .wide_i    (wide),
        .phase_i   (phase),
        .sel_i     (sel_i),
        .rnw_i     (rnw_i),
        .strobe_i  (strobe_i),
        .busy_i    (busy_i),
        .addr_i    (addr_i),
        .rdata_i   (rdata_i),
        .bus_out_o (bus_out_o),
        .bus_oe_o  (bus_oe_o)
    );

    assign wide_mode_o = wide;

    AST_NO_ACK_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && rd_ack_o)); // R12
endmodule

// File: tb/sim_hbus_port.sv
module sim_hbus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_i = 1'b0, rnw_i = 1'b0, strobe_i = 1'b0;
    logic [7:0] bus_in_i = 8'h00;
    logic [7:0] bus_out_o;
    logic       bus_oe_o;
    logic       busy_i = 1'b0;
    logic [6:0] addr_i = 7'h00;
    logic [7:0] rdata_i = 8'h00;
    logic       wr_valid_o;
    logic [7:0] wr_byte_o;
    logic       wr_is_data_o, wr_overrun_o, rd_ack_o, wide_mode_o;

    int tests = 0, fails = 0;
    int wr_cnt = 0, ack_cnt = 0;
    logic [7:0] last_byte = 8'h00;
    logic last_kind = 1'b0, last_ovr = 1'b0;
    logic [7:0] rd_seen;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbus_port u0 (.*);

    always @(negedge clk) begin
        if (wr_valid_o) begin
            wr_cnt++;
            last_byte = wr_byte_o;
            last_kind = wr_is_data_o;
            last_ovr  = wr_overrun_o;
        end
        if (rd_ack_o) ack_cnt++;
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(logic s, logic rw, logic [7:0] d);
        @(negedge clk);
        sel_i = s; rnw_i = rw; bus_in_i = d;
        repeat (2) @(negedge clk);
        strobe_i = 1'b1;
        repeat (4) @(negedge clk);
        rd_seen = bus_out_o;
        repeat (4) @(negedge clk);
        strobe_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 wide", {7'b0, wide_mode_o}, 8'h01);
        chk("R1 oe", {7'b0, bus_oe_o}, 8'h00);
        chk("R1 no handoff", wr_cnt[7:0], 8'h00);
    endtask

    task automatic t_oe;
        @(negedge clk);
        sel_i = 1'b1; rnw_i = 1'b0; strobe_i = 1'b1;
        @(negedge clk); chk("R3 write high", {7'b0, bus_oe_o}, 8'h00);
        strobe_i = 1'b0; rnw_i = 1'b1;
        @(negedge clk); chk("R3 read low", {7'b0, bus_oe_o}, 8'h00);
        strobe_i = 1'b1;
        @(negedge clk); chk("R3 read high", {7'b0, bus_oe_o}, 8'h01);
        strobe_i = 1'b0; rnw_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_write_full;
        int c0 = wr_cnt;
        strobe(1'b0, 1'b0, 8'h0C);
        chk("R2 instr byte", last_byte, 8'h0C);
        chk("R2 instr tag", {7'b0, last_kind}, 8'h00);
        strobe(1'b1, 1'b0, 8'hA5);
        chk("R2 data byte", last_byte, 8'hA5);
        chk("R2 data tag", {7'b0, last_kind}, 8'h01);
        chk("R12 count", 8'(wr_cnt - c0), 8'h02);
    endtask

    task automatic t_status_full;
        int c0 = wr_cnt, a0 = ack_cnt;
        busy_i = 1'b1; addr_i = 7'h45;
        strobe(1'b0, 1'b1, 8'h00);
        chk("R4 busy status", rd_seen, 8'hC5);
        busy_i = 1'b0; addr_i = 7'h12;
        strobe(1'b0, 1'b1, 8'h00);
        chk("R4 idle status", rd_seen, 8'h12);
        chk("R4 no handoff/ack", 8'((wr_cnt - c0) + (ack_cnt - a0)), 8'h00);
    endtask

    task automatic t_data_full;
        int a0 = ack_cnt;
        rdata_i = 8'h3C;
        strobe(1'b1, 1'b1, 8'h00);
        chk("R5 data", rd_seen, 8'h3C);
        chk("R5 ack", 8'(ack_cnt - a0), 8'h01);
    endtask

    task automatic t_overrun;
        busy_i = 1'b1;
        strobe(1'b1, 1'b0, 8'h11);
        busy_i = 1'b0;
        chk("R11 busy write", {7'b0, last_ovr}, 8'h01);
        strobe(1'b1, 1'b0, 8'h22);
        chk("R11 idle write", {7'b0, last_ovr}, 8'h00);
    endtask

    task automatic t_width_decode;
        strobe(1'b0, 1'b0, 8'h38);
        chk("R6 same width", {7'b0, wide_mode_o}, 8'h01);
        strobe(1'b1, 1'b0, 8'h20);
        chk("R6 data no switch", {7'b0, wide_mode_o}, 8'h01);
        strobe(1'b0, 1'b0, 8'h2F);
        chk("R6 to narrow", {7'b0, wide_mode_o}, 8'h00);
    endtask

    task automatic t_write_narrow;
        int c0 = wr_cnt;
        strobe(1'b1, 1'b0, 8'hAF);
        chk("R12 no handoff on first nibble", 8'(wr_cnt - c0), 8'h00);
        strobe(1'b1, 1'b0, 8'h5E);
        chk("R7 byte", last_byte, 8'hA5);
        chk("R7 tag", {7'b0, last_kind}, 8'h01);
        chk("R12 one handoff", 8'(wr_cnt - c0), 8'h01);
    endtask

    task automatic t_status_narrow;
        busy_i = 1'b1; addr_i = 7'h5B;
        strobe(1'b0, 1'b1, 8'h00);
        chk("R8 first nibble", rd_seen, 8'hD0);
        strobe(1'b0, 1'b1, 8'h00);
        chk("R8 second nibble", rd_seen, 8'hB0);
        busy_i = 1'b0;
    endtask

    task automatic t_data_narrow;
        int a0 = ack_cnt;
        rdata_i = 8'h96;
        strobe(1'b1, 1'b1, 8'h00);
        chk("R9 upper", rd_seen, 8'h90);
        chk("R9 no early ack", 8'(ack_cnt - a0), 8'h00);
        strobe(1'b1, 1'b1, 8'h00);
        chk("R9 lower", rd_seen, 8'h60);
        chk("R9 ack", 8'(ack_cnt - a0), 8'h01);
    endtask

    task automatic t_switch_back;
        strobe(1'b0, 1'b0, 8'h3F);
        strobe(1'b0, 1'b0, 8'h0F);
        chk("R6 to full", {7'b0, wide_mode_o}, 8'h01);
        chk("R6 byte", last_byte, 8'h30);
        addr_i = 7'h6E;
        strobe(1'b0, 1'b1, 8'h00);
        chk("R10 full read", rd_seen, 8'h6E);
        strobe(1'b0, 1'b0, 8'h20);
        chk("R10 narrow again", {7'b0, wide_mode_o}, 8'h00);
        strobe(1'b0, 1'b1, 8'h00);
        chk("R10 upper first", rd_seen, 8'h60);
        strobe(1'b0, 1'b1, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_oe();
        t_write_full();
        t_status_full();
        t_data_full();
        t_overrun();
        t_width_decode();
        t_write_narrow();
        t_status_narrow();
        t_data_narrow();
        t_switch_back();
        finish_run();
    end
endmodule